// File: doc/BRIEF.md
# Condition Code Flag Update Unit

This block keeps the 8-bit condition code register of a small 8-bit processor. At each clock edge it looks at a 4-bit instruction class code. It then rewrites only the flags that this class is allowed to change. The new values come from the ALU result, the ALU carry, overflow and half-carry signals, and a width indicator that marks the result as 8 or 16 bits. Classes that move data without computing anything leave the register alone. The interrupt mask bits and the stop-disable bit change only through a whole-register transfer or through the set and clear commands. The masks driven by `wr_data` select which bits those commands touch.

The register layout, from bit 7 down to bit 0, is: stop disable S, non-maskable interrupt mask X, half carry H, interrupt mask I, negative N, zero Z, overflow V, carry C. Each bit is also brought out as its own output for the branch logic.

Class codes: 0 hold, 1 add, 2 subtract, 3 compare, 4 shift or rotate, 5 multiply or divide, 6 index increment or decrement, 7 accumulator load or store, 8 transfer to register, 9 set bits, 10 clear bits, 11 to 15 hold.

Top module: `ccr_flag_unit`

## Requirements
- R1: While `rst_n` is low, the register reads 8'hD0: S, X and I are 1 and every other bit is 0.
- R2: For class 1 (add), C takes `alu_c` and V takes `alu_v`. Z is set when the result is zero: the low 8 bits when `wide`=0, all 16 bits when `wide`=1. N takes bit 7 of the result when `wide`=0 and bit 15 when `wide`=1. H takes `alu_h` only when `wide`=0 and is unchanged when `wide`=1.
- R3: For classes 2 (subtract) and 3 (compare), C, V, Z and N are updated as in R2, and H is unchanged.
- R4: For class 4 (shift or rotate), C takes the shifted-out bit given on `alu_c`. N and Z follow the result as in R2, and V becomes N XOR C of the new values.
- R5: For class 5 (multiply or divide), C takes `alu_c` as a status bit and Z follows the result. All other bits are unchanged.
- R6: For class 6 (index increment or decrement), only Z is updated, from the result. C, V, N and H are unchanged.
- R7: For class 7 (load or store), N and Z follow the data and V is cleared. C and H are unchanged.
- R8: Class 0 and classes 11 to 15 leave all eight bits unchanged.
- R9: Class 8 loads all eight bits from `wr_data`, except that X becomes 1 only if it was already 1 and `wr_data[6]` is 1.
- R10: Class 9 sets each bit whose `wr_data` bit is 1, but never sets X. Class 10 clears each bit whose `wr_data` bit is 1.
- R11: S, X and I change only under classes 8, 9 and 10.
- R12: Each single-flag output equals its bit of `ccr` at the position given above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_class | input | 4 | Instruction class code |
| wide | input | 1 | 1 when the result is 16 bits wide |
| result | input | 16 | ALU result or data moved |
| alu_c | input | 1 | Carry, borrow, shifted-out bit or error status |
| alu_v | input | 1 | Signed overflow |
| alu_h | input | 1 | Carry out of bit 3 |
| wr_data | input | 8 | Register image for transfer, or bit mask for set and clear |
| ccr | output | 8 | Register value |
| flag_c | output | 1 | Carry |
| flag_v | output | 1 | Overflow |
| flag_z | output | 1 | Zero |
| flag_n | output | 1 | Negative |
| flag_h | output | 1 | Half carry |
| mask_i | output | 1 | Interrupt mask |
| mask_x | output | 1 | Non-maskable interrupt mask |
| stop_dis | output | 1 | Stop disable |

## Verification
The bench uses the default 16-bit result width and the 8-bit byte width. It sweeps all 16 class codes against both widths, all eight carry, overflow and half-carry combinations, and a set of results that sit on the zero and sign boundaries of both widths. Before each step, a reset followed by a transfer sets one of several starting register images. This covers both states of the X mask and shows that the hold classes and the narrow classes keep every bit they do not own.

// File: rtl/ccr_flag_unit.sv
module ccr_flag_unit #(
  parameter int RES_W  = 16,
  parameter int BYTE_W = 8,
  parameter logic [7:0] RESET_VAL = 8'hD0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       op_class,
  input  logic             wide,
  input  logic [RES_W-1:0] result,
  input  logic             alu_c,
  input  logic             alu_v,
  input  logic             alu_h,
  input  logic [7:0]       wr_data,
  output logic [7:0]       ccr,
  output logic             flag_c,
  output logic             flag_v,
  output logic             flag_z,
  output logic             flag_n,
  output logic             flag_h,
  output logic             mask_i,
  output logic             mask_x,
  output logic             stop_dis
);
  localparam int BC = 0, BV = 1, BZ = 2, BN = 3, BI = 4, BH = 5, BX = 6, BS = 7;
  localparam logic [3:0] K_ADD = 4'd1, K_SUB = 4'd2, K_CMP = 4'd3, K_SHF = 4'd4,
                         K_MUL = 4'd5, K_IDX = 4'd6, K_LDS = 4'd7, K_XFR = 4'd8,
                         K_SET = 4'd9, K_CLR = 4'd10;

  logic [7:0] q, d;
  logic zr, nr;

  assign zr = wide ? (result == '0) : (result[BYTE_W-1:0] == '0);
  assign nr = wide ? result[RES_W-1] : result[BYTE_W-1];

  always_comb begin
    d = q;
    unique case (op_class)
      K_ADD: begin
        d[BC] = alu_c; d[BV] = alu_v; d[BZ] = zr; d[BN] = nr;
        if (!wide) d[BH] = alu_h;
      end
      K_SUB, K_CMP: begin
        d[BC] = alu_c; d[BV] = alu_v; d[BZ] = zr; d[BN] = nr;
      end
      K_SHF: begin
        d[BC] = alu_c; d[BZ] = zr; d[BN] = nr; d[BV] = nr ^ alu_c;
      end
      K_MUL: begin
        d[BC] = alu_c; d[BZ] = zr;
      end
      K_IDX: d[BZ] = zr;
      K_LDS: begin
        d[BZ] = zr; d[BN] = nr; d[BV] = 1'b0;
      end
      K_XFR: begin
        d = wr_data;
        d[BX] = q[BX] & wr_data[BX];
      end
      K_SET: begin
        d = q | wr_data;
        d[BX] = q[BX];
      end
      K_CLR: d = q & ~wr_data;
      default: d = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) q <= RESET_VAL;
    else        q <= d;

  assign ccr      = q;
  assign flag_c   = q[BC];
  assign flag_v   = q[BV];
  assign flag_z   = q[BZ];
  assign flag_n   = q[BN];
  assign flag_h   = q[BH];
  assign mask_i   = q[BI];
  assign mask_x   = q[BX];
  assign stop_dis = q[BS];

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_class == 4'd0 || op_class > K_CLR) |=> (ccr == $past(ccr)));
  p_x_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ccr[BX] |=> !ccr[BX]);
  p_masks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_class < K_XFR || op_class > K_CLR) |=> $stable({ccr[BS], ccr[BX], ccr[BI]}));
  p_idx_only_z_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_class == K_IDX) |=> ({ccr[7:3], ccr[1:0]} == $past({ccr[7:3], ccr[1:0]})));
  p_lds_v_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_class == K_LDS) |=> (!ccr[BV] && $stable({ccr[BC], ccr[BH]})));
  p_half_wide_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_class == K_ADD && wide) |=> $stable(ccr[BH]));
endmodule

// File: tb/sim_ccr_flag_unit.sv
module sim_ccr_flag_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] op_class = 4'd0;
  logic wide = 1'b0, alu_c = 1'b0, alu_v = 1'b0, alu_h = 1'b0;
  logic [15:0] result = 16'h0;
  logic [7:0] wr_data = 8'h0;
  logic [7:0] ccr;
  logic flag_c, flag_v, flag_z, flag_n, flag_h, mask_i, mask_x, stop_dis;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ccr_flag_unit u0 (.clk(clk), .rst_n(rst_n), .op_class(op_class), .wide(wide),
    .result(result), .alu_c(alu_c), .alu_v(alu_v), .alu_h(alu_h), .wr_data(wr_data),
    .ccr(ccr), .flag_c(flag_c), .flag_v(flag_v), .flag_z(flag_z), .flag_n(flag_n),
    .flag_h(flag_h), .mask_i(mask_i), .mask_x(mask_x), .stop_dis(stop_dis));

  function automatic logic [7:0] model(input logic [3:0] k, input logic w,
      input logic [15:0] r, input logic c, input logic v, input logic h,
      input logic [7:0] m, input logic [7:0] cur);
    logic [7:0] e;
    logic z, n;
    e = cur;
    z = w ? (r == 16'h0) : (r[7:0] == 8'h0);
    n = w ? r[15] : r[7];
    case (k)
      4'd1: begin e[0] = c; e[1] = v; e[2] = z; e[3] = n; if (!w) e[5] = h; end
      4'd2, 4'd3: begin e[0] = c; e[1] = v; e[2] = z; e[3] = n; end
      4'd4: begin e[0] = c; e[2] = z; e[3] = n; e[1] = (n != c); end
      4'd5: begin e[0] = c; e[2] = z; end
      4'd6: e[2] = z;
      4'd7: begin e[2] = z; e[3] = n; e[1] = 1'b0; end
      4'd8: e = {m[7], m[6] & cur[6], m[5:0]};
      4'd9: e = {cur[7] | m[7], cur[6], cur[5:0] | m[5:0]};
      4'd10: e = cur & ~m;
      default: e = cur;
    endcase
    return e;
  endfunction

  function automatic string tag(input logic [3:0] k);
    case (k)
      4'd1: return "R2";
      4'd2, 4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R9";
      4'd9, 4'd10: return "R10";
      default: return "R8";
    endcase
  endfunction

  task automatic check8(input string rq, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic check_outs;
    check8("R12", {stop_dis, mask_x, flag_h, mask_i, flag_n, flag_z, flag_v, flag_c}, ccr);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    op_class = 4'd0;
    #2;
    check8("R1", ccr, 8'hD0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic apply(input logic [3:0] k, input logic w, input logic [15:0] r,
      input logic [2:0] cvh, input logic [7:0] m);
    op_class = k; wide = w; result = r;
    {alu_c, alu_v, alu_h} = cvh; wr_data = m;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [15:0] pats [6];
    logic [7:0] starts [4];
    logic [7:0] cur, exp;
    pats[0] = 16'h0000; pats[1] = 16'h0080; pats[2] = 16'h8000;
    pats[3] = 16'h00FF; pats[4] = 16'h0100; pats[5] = 16'h7F00;
    starts[0] = 8'h00; starts[1] = 8'hFF; starts[2] = 8'h5A; starts[3] = 8'hE5;
    do_reset();
    check_outs();
    for (int k = 0; k < 16; k++)
      for (int w = 0; w < 2; w++)
        for (int f = 0; f < 8; f++)
          for (int p = 0; p < 6; p++)
            for (int s = 0; s < 4; s++) begin
              do_reset();
              apply(4'd8, 1'b0, 16'h0, 3'd0, starts[s]);
              cur = model(4'd8, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, starts[s], 8'hD0);
              check8("R9", ccr, cur);
              exp = model(k[3:0], w[0], pats[p], f[2], f[1], f[0],
                          pats[p][7:0] ^ 8'h5A, cur);
              apply(k[3:0], w[0], pats[p], f[2:0], pats[p][7:0] ^ 8'h5A);
              check8(tag(k[3:0]), ccr, exp);
              if (k < 8 || k > 10)
                check8("R11", {ccr[7], ccr[6], ccr[4], 5'd0}, {cur[7], cur[6], cur[4], 5'd0});
              check_outs();
            end
    do_reset();
    apply(4'd10, 1'b0, 16'h0, 3'd0, 8'h40);
    check8("R10", ccr, 8'h90);
    apply(4'd8, 1'b0, 16'h0, 3'd0, 8'hFF);
    check8("R9", ccr, 8'hBF);
    apply(4'd9, 1'b0, 16'h0, 3'd0, 8'h40);
    check8("R10", ccr, 8'hBF);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual timeout expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule